// File: doc/BRIEF.md
# Failed-Word Healer CAM

This block is a small replacement store for a memory controller. It remembers up to 32 physical word addresses that are known to be faulty. For each one it keeps a replacement data word that is wide enough for the data and its check bits. Every access address is compared in parallel against all occupied entries. When one of them matches, the access is served from the replacement word and main memory is bypassed. The lookup is purely combinational, so a redirected access takes the same number of cycles as any other access.

Heal requests come from the error-correction path. Each one carries a failed address and the corrected word, and arrives on a valid/ready channel. A request for an address that is already held refreshes that entry's data. A request for a new address takes the lowest-numbered free entry. When the store is full, new addresses are dropped and no tag changes. A sticky overflow flag reports that the store has filled. Software can read any entry, free a single entry, and clear the overflow flag. When it is cleared, the flag is recomputed from the current occupancy.

Back-pressure on the heal channel is simple. heal_ready is low in any cycle in which software frees an entry. A request is taken only in a cycle in which heal_valid and heal_ready are both high. The source must hold its request until then. A request taken while the store is full and the address is new is consumed and discarded.

Top module: `healer_cam`

## Requirements
- R1: After reset every entry is free (bit 0 of sw_tag is 0 for every index), ovf is 0 and acc_hit is 0.
- R2: In the same cycle that acc_valid is high and acc_addr equals the tag of an occupied entry, acc_hit is 1 and acc_rdata equals that entry's data, with no added cycle.
- R3: An address held in no occupied entry gives acc_hit 0, and a freed entry no longer matches its old address.
- R4: An accepted heal for an address held in no entry writes the lowest-index free entry. From the next cycle sw_tag for that index reads {heal_addr, 1'b1} (address in bits 18:1, valid in bit 0) and sw_data reads heal_data.
- R5: An accepted heal for an address that is already held replaces only that entry's data. No other entry becomes occupied.
- R6: An access with acc_write high that hits replaces the entry's data with acc_wdata from the next cycle. A write that misses changes no entry.
- R7: While all entries are occupied, a heal for a new address is consumed but changes no tag and no data.
- R8: ovf becomes 1 in the cycle after the one in which all entries are first occupied. It stays 1 until sw_clr_ovf.
- R9: A pulse on sw_clr_entry frees entry sw_idx from the next cycle, and the next new-address heal can reuse it in lowest-index order.
- R10: On sw_clr_ovf, ovf takes the value "all entries occupied" as it stood in that cycle. Clearing the flag while the store is full leaves it at 1.
- R11: heal_ready is 0 in a cycle with sw_clr_entry high. A heal presented then is not taken and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A memory access is presented |
| acc_write | input | 1 | The access is a write |
| acc_addr | input | 18 | Physical word address of the access |
| acc_wdata | input | 39 | Write word (data and check bits) |
| acc_hit | output | 1 | The access is redirected to the healer |
| acc_rdata | output | 39 | Replacement word of the hit entry |
| heal_valid | input | 1 | Heal request present |
| heal_ready | output | 1 | Heal request can be taken this cycle |
| heal_addr | input | 18 | Failed physical address |
| heal_data | input | 39 | Corrected word |
| sw_idx | input | 5 | Entry selected by software |
| sw_clr_entry | input | 1 | Free the selected entry |
| sw_clr_ovf | input | 1 | Clear and recompute the overflow flag |
| sw_tag | output | 19 | Selected entry: address in bits 18:1, valid in bit 0 |
| sw_data | output | 39 | Selected entry replacement word |
| ovf | output | 1 | Sticky healer-overflow flag |

## Verification
Some rules are checked by the assertions on every cycle. A hit requires an occupied entry. A new-address heal adds exactly one entry, and a refresh heal leaves the tags alone. A full store keeps its tags frozen unless software frees an entry. The overflow flag follows a full store and stays set. A freed entry really becomes free. Other behaviour only shows up at the ports in the bench's scenarios. Those scenarios show that allocation goes to the lowest free index and that a refresh lands in the right entry. They show that a redirected word comes back in the same cycle, that a hit write updates the entry, and that a miss write leaves the store alone. They also cover the exact cycle in which overflow rises, the recomputation when the flag is cleared while the store is still full, and the refusal of a heal during a software clear.

// File: rtl/healer_pkg.sv
package healer_pkg;
  parameter int HEAL_ENTRIES = 32;
  parameter int HEAL_ADDR_W  = 18;
  parameter int HEAL_DATA_W  = 39;
endpackage

// File: rtl/healer_match.sv
module healer_match #(
  parameter int N  = 32,
  parameter int AW = 18,
  parameter int DW = 39
) (
  input  logic [AW-1:0]         key,
  input  logic [N-1:0]          valid_vec,
  input  logic [N-1:0][AW-1:0]  tags,
  input  logic [N-1:0][DW-1:0]  datas,
  output logic                  hit,
  output logic [N-1:0]          hit_oh,
  output logic [DW-1:0]         hit_data
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_oh[g] = valid_vec[g] && (tags[g] == key);
  end

  assign hit = |hit_oh;

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_oh[i]) hit_data = hit_data | datas[i];
    end
  end
endmodule

// File: rtl/healer_alloc.sv
module healer_alloc #(
  parameter int N = 32
) (
  input  logic [N-1:0] valid_vec,
  output logic         any_free,
  output logic [N-1:0] free_oh
);
  always_comb begin
    free_oh = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_oh = N'(1) << i;
    end
  end

  assign any_free = ~&valid_vec;
endmodule

// File: rtl/healer_store.sv
module healer_store #(
  parameter int N  = 32,
  parameter int AW = 18,
  parameter int DW = 39
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          clr_oh,
  input  logic [N-1:0]          new_oh,
  input  logic [N-1:0]          upd_oh,
  input  logic [N-1:0]          wr_oh,
  input  logic [AW-1:0]         heal_addr,
  input  logic [DW-1:0]         heal_data,
  input  logic [DW-1:0]         wr_data,
  output logic [N-1:0]          valid_q,
  output logic [N-1:0][AW-1:0]  tag_q,
  output logic [N-1:0][DW-1:0]  data_q
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
      end else if (clr_oh[g]) begin
        valid_q[g] <= 1'b0;
      end else if (new_oh[g]) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= heal_addr;
        data_q[g]  <= heal_data;
      end else if (upd_oh[g]) begin
        data_q[g]  <= heal_data;
      end else if (wr_oh[g]) begin
        data_q[g]  <= wr_data;
      end
    end
  end
endmodule

// File: rtl/healer_cam.sv
module healer_cam
  import healer_pkg::*;
#(
  parameter int ENTRIES = HEAL_ENTRIES,
  parameter int ADDR_W  = HEAL_ADDR_W,
  parameter int DATA_W  = HEAL_DATA_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_hit,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              heal_valid,
  output logic              heal_ready,
  input  logic [ADDR_W-1:0] heal_addr,
  input  logic [DATA_W-1:0] heal_data,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic              sw_clr_entry,
  input  logic              sw_clr_ovf,
  output logic [ADDR_W:0]   sw_tag,
  output logic [DATA_W-1:0] sw_data,
  output logic              ovf
);
  logic [ENTRIES-1:0]              valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0]  tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0]  data_q;

  logic                acc_match;
  logic [ENTRIES-1:0]  acc_oh;
  logic                heal_hit;
  logic [ENTRIES-1:0]  heal_oh;
  logic [DATA_W-1:0]   heal_unused;
  logic                any_free;
  logic [ENTRIES-1:0]  free_oh;
  logic                heal_fire;
  logic [ENTRIES-1:0]  clr_oh, new_oh, upd_oh, wr_oh;
  logic                full_now;
  logic                ovf_q;

  healer_match #(.N(ENTRIES), .AW(ADDR_W), .DW(DATA_W)) u_acc_match (
    .key(acc_addr), .valid_vec(valid_q), .tags(tag_q), .datas(data_q),
    .hit(acc_match), .hit_oh(acc_oh), .hit_data(acc_rdata)
  );

  healer_match #(.N(ENTRIES), .AW(ADDR_W), .DW(DATA_W)) u_heal_match (
    .key(heal_addr), .valid_vec(valid_q), .tags(tag_q), .datas(data_q),
    .hit(heal_hit), .hit_oh(heal_oh), .hit_data(heal_unused)
  );

  healer_alloc #(.N(ENTRIES)) u_alloc (
    .valid_vec(valid_q), .any_free(any_free), .free_oh(free_oh)
  );

  assign acc_hit    = acc_valid && acc_match;
  assign heal_ready = !sw_clr_entry;
  assign heal_fire  = heal_valid && heal_ready;
  assign full_now   = &valid_q;

  assign clr_oh = sw_clr_entry ? (ENTRIES'(1) << sw_idx) : '0;
  assign new_oh = (heal_fire && !heal_hit && any_free) ? free_oh : '0;
  assign upd_oh = (heal_fire && heal_hit) ? heal_oh : '0;
  assign wr_oh  = (acc_valid && acc_write) ? acc_oh : '0;

  healer_store #(.N(ENTRIES), .AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .clr_oh(clr_oh), .new_oh(new_oh), .upd_oh(upd_oh), .wr_oh(wr_oh),
    .heal_addr(heal_addr), .heal_data(heal_data), .wr_data(acc_wdata),
    .valid_q(valid_q), .tag_q(tag_q), .data_q(data_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_q <= 1'b0;
    else if (sw_clr_ovf) ovf_q <= full_now;
    else if (full_now)   ovf_q <= 1'b1;
  end

  assign ovf     = ovf_q;
  assign sw_tag  = {tag_q[sw_idx], valid_q[sw_idx]};
  assign sw_data = data_q[sw_idx];
endmodule

// File: rtl/healer_cam_chk.sv
module healer_cam_chk #(
  parameter int N     = 32,
  parameter int AW    = 18,
  parameter int IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         valid_q,
  input logic [N-1:0][AW-1:0] tag_q,
  input logic                 acc_hit,
  input logic                 heal_valid,
  input logic                 heal_ready,
  input logic                 heal_hit,
  input logic                 sw_clr_entry,
  input logic                 sw_clr_ovf,
  input logic [IDX_W-1:0]     sw_idx,
  input logic                 ovf
);
  logic fire;
  assign fire = heal_valid && heal_ready;

  assert_hit_has_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> (valid_q != '0));

  assert_alloc_adds_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !heal_hit && !(&valid_q)) |=>
      ($countones(valid_q) == $past($countones(valid_q)) + 1));

  assert_refresh_keeps_tags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && heal_hit) |=> ($stable(valid_q) && $stable(tag_q)));

  assert_full_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&valid_q) && !sw_clr_entry) |=> ($stable(valid_q) && $stable(tag_q)));

  assert_full_sets_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_q) |=> ovf);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !sw_clr_ovf) |=> ovf);

  assert_clear_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_entry |=> !valid_q[$past(sw_idx)]);

  assert_busy_blocks_heal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_entry && heal_valid && !heal_hit && !(&valid_q)) |=>
      ($countones(valid_q) < $past($countones(valid_q)) + 1));
endmodule

bind healer_cam healer_cam_chk #(.N(ENTRIES), .AW(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_q(valid_q), .tag_q(tag_q),
  .acc_hit(acc_hit), .heal_valid(heal_valid), .heal_ready(heal_ready),
  .heal_hit(heal_hit), .sw_clr_entry(sw_clr_entry), .sw_clr_ovf(sw_clr_ovf),
  .sw_idx(sw_idx), .ovf(ovf)
);

// File: tb/test_healer_cam.sv
module test_healer_cam;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int AW = 18;
  localparam int DW = 39;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic acc_hit;
  logic [DW-1:0] acc_rdata;
  logic heal_valid = 0;
  logic heal_ready;
  logic [AW-1:0] heal_addr = '0;
  logic [DW-1:0] heal_data = '0;
  logic [4:0] sw_idx = '0;
  logic sw_clr_entry = 0, sw_clr_ovf = 0;
  logic [AW:0] sw_tag;
  logic [DW-1:0] sw_data;
  logic ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  healer_cam i_healer_cam (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_hit(acc_hit), .acc_rdata(acc_rdata),
    .heal_valid(heal_valid), .heal_ready(heal_ready), .heal_addr(heal_addr),
    .heal_data(heal_data), .sw_idx(sw_idx), .sw_clr_entry(sw_clr_entry),
    .sw_clr_ovf(sw_clr_ovf), .sw_tag(sw_tag), .sw_data(sw_data), .ovf(ovf)
  );

  // reference model built from the requirements
  logic          m_val [N];
  logic [AW-1:0] m_tag [N];
  logic [DW-1:0] m_dat [N];
  logic          m_ovf;

  typedef struct {
    int          kind;   // 0 access, 1 sw entry, 2 ovf, 3 ready
    string       req;
    logic [63:0] e1;
    logic [63:0] e2;
  } item_t;
  item_t q[$];

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic int find(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (!m_val[i]) return i;
    return -1;
  endfunction

  function automatic bit all_full();
    for (int i = 0; i < N; i++) if (!m_val[i]) return 0;
    return 1;
  endfunction

  task automatic step(input bit hv, input logic [AW-1:0] ha, input logic [DW-1:0] hd,
                      input bit av, input bit aw, input logic [AW-1:0] aa,
                      input logic [DW-1:0] ad, input bit ce, input bit co,
                      input logic [4:0] si, input bit c_acc, input bit c_sw,
                      input bit c_ovf, input bit c_rdy, input string req);
    item_t it;
    int ai, hi, fi;
    bit full_b;
    @(negedge clk);
    heal_valid = hv; heal_addr = ha; heal_data = hd;
    acc_valid = av; acc_write = aw; acc_addr = aa; acc_wdata = ad;
    sw_clr_entry = ce; sw_clr_ovf = co; sw_idx = si;
    #1;
    ai = find(aa);
    if (c_acc) begin
      it.kind = 0; it.req = req; it.e1 = 64'(ai >= 0);
      it.e2 = (ai >= 0) ? 64'(m_dat[ai]) : 64'd0;
      q.push_back(it);
    end
    if (c_sw) begin
      it.kind = 1; it.req = req; it.e1 = 64'({m_tag[si], m_val[si]});
      it.e2 = 64'(m_dat[si]);
      q.push_back(it);
    end
    if (c_ovf) begin
      it.kind = 2; it.req = req; it.e1 = 64'(m_ovf); it.e2 = 0;
      q.push_back(it);
    end
    if (c_rdy) begin
      it.kind = 3; it.req = req; it.e1 = 64'(!ce); it.e2 = 0;
      q.push_back(it);
    end
    @(posedge clk);
    full_b = all_full();
    m_ovf = co ? full_b : (m_ovf | full_b);
    hi = find(ha);
    fi = lowest_free();
    if (av && aw && ai >= 0) m_dat[ai] = ad;
    if (hv && !ce) begin
      if (hi >= 0) m_dat[hi] = hd;
      else if (fi >= 0) begin m_val[fi] = 1; m_tag[fi] = ha; m_dat[fi] = hd; end
    end
    if (ce) m_val[si] = 0;
    #1;
    heal_valid = 0; acc_valid = 0; acc_write = 0;
    sw_clr_entry = 0; sw_clr_ovf = 0;
  endtask

  task automatic heal(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    step(1, a, d, 0, 0, '0, '0, 0, 0, '0, 0, 0, 0, 1, req);
  endtask
  task automatic probe_acc(input logic [AW-1:0] a, input string req);
    step(0, '0, '0, 1, 0, a, '0, 0, 0, '0, 1, 0, 1, 0, req);
  endtask
  task automatic probe_sw(input logic [4:0] i, input string req);
    step(0, '0, '0, 0, 0, '0, '0, 0, 0, i, 0, 1, 1, 0, req);
  endtask
  task automatic acc_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    step(0, '0, '0, 1, 1, a, d, 0, 0, '0, 1, 0, 0, 0, req);
  endtask

  // monitor
  initial begin
    item_t it;
    logic [63:0] a1, a2;
    bit bad;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      bad = 0; a2 = 0;
      case (it.kind)
        0: begin a1 = 64'(acc_hit); a2 = it.e1[0] ? 64'(acc_rdata) : 64'd0;
                 bad = (a1 != it.e1) || (a2 != it.e2); end
        1: begin a1 = 64'(sw_tag); a2 = it.e1[0] ? 64'(sw_data) : it.e2;
                 bad = (a1 != it.e1) || (a2 != it.e2); end
        2: begin a1 = 64'(ovf); bad = (a1 != it.e1); end
        default: begin a1 = 64'(heal_ready); bad = (a1 != it.e1); end
      endcase
      n_cmp++;
      if (bad) begin
        n_bad++;
        $display("FAIL %s kind %0d: actual %h/%h expected %h/%h",
                 it.req, it.kind, a1, a2, it.e1, it.e2);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
    m_ovf = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    probe_sw(5'd0, "R1 entry0 free");
    probe_sw(5'd31, "R1 entry31 free");
    probe_acc(18'h00005, "R1 R3 no hit after reset");

    // R4 allocation lowest first, R2 same-cycle hit
    heal(18'h01234, 39'h12_3456_789A, "R4 first heal");
    probe_sw(5'd0, "R4 entry0 written");
    probe_acc(18'h01234, "R2 hit returns word");
    heal(18'h02222, 39'h22_2222_2222, "R4 second heal");
    probe_sw(5'd1, "R4 entry1 written");

    // R5 refresh of existing address
    heal(18'h01234, 39'h7F_0000_0001, "R5 refresh heal");
    probe_sw(5'd0, "R5 entry0 refreshed");
    probe_sw(5'd2, "R5 entry2 still free");

    // R6 writes
    acc_wr(18'h02222, 39'h0A_BCDE_F012, "R6 write hit");
    probe_acc(18'h02222, "R6 write data seen");
    acc_wr(18'h03333, 39'h55_5555_5555, "R6 write miss");
    probe_sw(5'd0, "R6 miss kept entry0");
    probe_sw(5'd1, "R6 miss kept entry1");
    probe_acc(18'h03333, "R6 R3 miss address no hit");

    // R11 clear with heal present, R9 clear
    step(1, 18'h04444, 39'h44, 0, 0, '0, '0, 1, 0, 5'd0, 0, 0, 0, 1, "R11 ready low in clear");
    probe_sw(5'd0, "R9 entry0 freed");
    probe_sw(5'd2, "R11 blocked heal not stored");
    probe_acc(18'h01234, "R3 freed entry no hit");
    heal(18'h05555, 39'h05_5555, "R9 reuse heal");
    probe_sw(5'd0, "R9 entry0 reused");

    // fill up
    for (int k = 2; k < N; k++) heal(18'h10000 + 18'(k), 39'(k) * 39'h101, "R4 fill");
    probe_sw(5'd31, "R8 last entry filled, ovf not yet");
    probe_sw(5'd31, "R8 ovf set next cycle");

    // R7 dropped while full
    heal(18'h3FFFF, 39'h66, "R7 heal while full");
    probe_acc(18'h3FFFF, "R7 dropped address no hit");
    probe_sw(5'd17, "R7 entry17 unchanged");

    // R10 recompute while full
    step(0, '0, '0, 0, 0, '0, '0, 0, 1, 5'd0, 0, 0, 1, 0, "R10 clear ovf while full");
    probe_sw(5'd0, "R10 ovf stays set");
    step(0, '0, '0, 0, 0, '0, '0, 1, 0, 5'd5, 0, 0, 0, 1, "R9 free entry5");
    probe_sw(5'd5, "R8 ovf sticky after free");
    step(0, '0, '0, 0, 0, '0, '0, 0, 1, 5'd0, 0, 0, 1, 0, "R10 clear ovf not full");
    probe_sw(5'd5, "R10 ovf cleared");
    heal(18'h2ABCD, 39'h77_7777, "R9 refill entry5");
    probe_sw(5'd5, "R9 entry5 reused, ovf not yet");
    probe_sw(5'd5, "R8 ovf set again");
    probe_acc(18'h2ABCD, "R2 hit on refilled entry");

    @(negedge clk);
    wait (q.size() == 0);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule